// File: doc/BRIEF.md
# Clock Frequency Select Controller

This block is the decision logic in front of a programmable clock synthesizer. It chooses the setting handed to the PLL: a gear code and, in programmable mode, an N/M divider pair. The candidates are strap pins captured at power-up, a select field written by firmware, and explicit N/M values. A configuration bus writes bytes into a small register file. Each byte carries an address, and a last-byte flag marks the end of a multi-byte transaction.

Every accepted change is announced to the PLL with a one-cycle load strobe. N/M pairs whose ratio would not exceed one are never applied. Instead they raise a sticky error flag.

A watchdog counts millisecond ticks. If firmware stops kicking it, the block falls back on its own to a recovery setting. It can also emit a fixed-length reset pulse, either on that timeout or after any software-driven change.

Top module: `fsc_top`

## Requirements
- R1: After reset, every output is 0. All registers clear, so the gear source is the latched strap value, which is 0 until the first latch.
- R2: The strap pins are captured only while `porLatch` is high. That capture also starts an evaluation, so the active setting moves one cycle later. Strap changes at any other time have no effect.
- R3: Register map: 0 = control (bit0 programmable enable, bit1 override, bit2 recovery source, bit3 long timeout, bit4 pulse on timeout, bit5 pulse on change, bit6 watchdog enable, bit7 write-1 clear of the error flag); 1 = select[4:0]; 2 = N; 3 = M[6:0]; 4 = recovery N; 5 = recovery M[6:0]. With programmable enable at 0, `gearSel` = override ? select : latched strap, and `nmMode`, `nVal` and `mVal` are 0.
- R4: With programmable enable at 1 and N > M, `gearSel` follows the same override rule, `nVal`/`mVal` carry N and M, and `nmMode` is 1.
- R5: A transaction that writes any of addresses 0 to 3 is evaluated once its last byte is written. Bytes may be split across idle cycles. `loadStb` pulses for exactly one cycle, one cycle after the last byte. This happens if the transaction wrote N or M, or if the resulting setting differs from the active one; otherwise no strobe is given. Outputs change only together with `loadStb`.
- R6: With programmable enable at 1 and N <= M, the evaluation is rejected. Outputs stay put, no strobe is given, and `ratioErr` is set. The flag stays set until a control write with bit7 = 1, and a rejection in the same evaluation wins over the clear.
- R7: The watchdog runs only while enabled. A kick restarts it. A timeout fires on the 150th tick (short) or the 2500th tick (long) after the last restart, and a kick in the same cycle as a tick wins.
- R8: On timeout the active setting becomes the latched strap gear with `nmMode` 0. The exception is when the recovery source is 1 and recovery N > recovery M: then the gear is the latched strap and N/M are the recovery pair with `nmMode` 1. A strobe is given, and a timeout takes precedence over an evaluation in the same cycle.
- R9: `rstPulse` goes high for exactly 16 cycles, starting together with `loadStb`. It fires on a timeout when pulse-on-timeout is set, and on an applied software change when pulse-on-change is set; otherwise it stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register byte write enable |
| wrAddr | input | 3 | Register address |
| wrData | input | 8 | Write data byte |
| wrLast | input | 1 | Marks the final byte of a transaction |
| strapPins | input | 5 | Frequency strap pins |
| porLatch | input | 1 | Strap capture strobe |
| msTick | input | 1 | One-cycle millisecond tick |
| wdKick | input | 1 | Watchdog restart |
| gearSel | output | 5 | Active gear code for the PLL |
| nVal | output | 8 | Active N divider value |
| mVal | output | 7 | Active M divider value |
| nmMode | output | 1 | N/M pair governs the PLL |
| loadStb | output | 1 | One-cycle load request to the PLL |
| rstPulse | output | 1 | System reset pulse |
| ratioErr | output | 1 | Sticky rejected-ratio flag |

## Verification
The bench targets N and M arriving as separate bytes with idle cycles between them. A design that acted on every byte would strobe twice and would briefly apply a half-updated pair. It also uses N equal to M as the rejection edge: an off-by-one compare would load a unity ratio and never set the error flag. The watchdog is sampled one tick before and exactly at the 150- and 2500-tick limits, with kicks spaced inside the window, which exposes an early or late timeout and a kick that fails to restart the count. The reset pulse is counted cycle by cycle against both enable bits, to catch a pulse that is too long, too short, or that fires without its enable.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int GEAR_W = 5;
  localparam int N_W    = 8;
  localparam int M_W    = 7;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL = 3'd0,
    ADR_SEL  = 3'd1,
    ADR_N    = 3'd2,
    ADR_M    = 3'd3,
    ADR_RN   = 3'd4,
    ADR_RM   = 3'd5
  } regAddr_e;

  typedef struct packed {
    logic              progEn;
    logic              override;
    logic              recSrc;
    logic              wdLong;
    logic              rstOnWd;
    logic              rstOnChg;
    logic              wdEn;
    logic [GEAR_W-1:0] sel;
    logic [GEAR_W-1:0] strap;
    logic [N_W-1:0]    n;
    logic [M_W-1:0]    m;
    logic [N_W-1:0]    rn;
    logic [M_W-1:0]    rm;
  } fscCfg_t;

  typedef struct packed {
    logic eval;
    logic nmWr;
    logic errClr;
  } fscStb_t;
endpackage

// File: rtl/fsc_ctrl.sv
module fsc_ctrl
  import fsc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrLast,
  input  logic [GEAR_W-1:0] strapPins,
  input  logic              porLatch,
  output fscCfg_t           cfg,
  output fscStb_t           stb
);
  logic pendCfg, pendNm;
  logic hitCfg, hitNm, xactEnd;

  always_comb begin
    hitCfg  = wrEn && (wrAddr <= ADR_M);
    hitNm   = wrEn && ((wrAddr == ADR_N) || (wrAddr == ADR_M));
    xactEnd = wrEn && wrLast;
  end

  // register file and strap capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else begin
      if (porLatch) cfg.strap <= strapPins;
      if (wrEn) begin
        case (wrAddr)
          ADR_CTRL: {cfg.wdEn, cfg.rstOnChg, cfg.rstOnWd, cfg.wdLong,
                     cfg.recSrc, cfg.override, cfg.progEn} <= wrData[6:0];
          ADR_SEL:  cfg.sel <= wrData[GEAR_W-1:0];
          ADR_N:    cfg.n   <= wrData[N_W-1:0];
          ADR_M:    cfg.m   <= wrData[M_W-1:0];
          ADR_RN:   cfg.rn  <= wrData[N_W-1:0];
          ADR_RM:   cfg.rm  <= wrData[M_W-1:0];
          default:  ;
        endcase
      end
    end
  end

  // transaction tracking: one evaluation per transaction end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCfg <= 1'b0;
      pendNm  <= 1'b0;
      stb     <= '0;
    end else begin
      stb.eval   <= porLatch || (xactEnd && (pendCfg || hitCfg));
      stb.nmWr   <= xactEnd && (pendNm || hitNm);
      stb.errClr <= wrEn && (wrAddr == ADR_CTRL) && wrData[7];
      if (xactEnd) begin
        pendCfg <= 1'b0;
        pendNm  <= 1'b0;
      end else begin
        pendCfg <= pendCfg || hitCfg;
        pendNm  <= pendNm || hitNm;
      end
    end
  end
endmodule

// File: rtl/fsc_dpath.sv
module fsc_dpath
  import fsc_pkg::*;
#(
  parameter int SHORT_TICKS  = 150,
  parameter int LONG_TICKS   = 2500,
  parameter int PULSE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fscCfg_t           cfg,
  input  fscStb_t           stb,
  input  logic              msTick,
  input  logic              wdKick,
  output logic [GEAR_W-1:0] gearSel,
  output logic [N_W-1:0]    nVal,
  output logic [M_W-1:0]    mVal,
  output logic              nmMode,
  output logic              loadStb,
  output logic              rstPulse,
  output logic              ratioErr
);
  localparam int MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int WD_W      = $clog2(MAX_TICKS) + 1;
  localparam int PC_W      = $clog2(PULSE_CYCLES + 1);

  logic [WD_W-1:0] wdCnt, wdLimit;
  logic            wdFire;
  logic [PC_W-1:0] pulseCnt;

  logic [GEAR_W-1:0] swGear, recGear;
  logic [N_W-1:0]    swN, recN;
  logic [M_W-1:0]    swM, recM;
  logic              swNm, recNm, swValid, swChange, swApply, swReject;

  // watchdog
  always_comb begin
    wdLimit = cfg.wdLong ? WD_W'(LONG_TICKS - 1) : WD_W'(SHORT_TICKS - 1);
    wdFire  = cfg.wdEn && msTick && !wdKick && (wdCnt >= wdLimit);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             wdCnt <= '0;
    else if (!cfg.wdEn || wdKick || wdFire) wdCnt <= '0;
    else if (msTick)                       wdCnt <= wdCnt + 1'b1;
  end

  // candidate settings
  always_comb begin
    swGear   = cfg.override ? cfg.sel : cfg.strap;
    swNm     = cfg.progEn;
    swN      = cfg.progEn ? cfg.n : '0;
    swM      = cfg.progEn ? cfg.m : '0;
    swValid  = !cfg.progEn || (N_W'(cfg.m) < cfg.n);
    swChange = {swGear, swN, swM, swNm} != {gearSel, nVal, mVal, nmMode};
    swApply  = stb.eval && swValid && (stb.nmWr || swChange) && !wdFire;
    swReject = stb.eval && !swValid && !wdFire;

    recNm   = cfg.recSrc && (N_W'(cfg.rm) < cfg.rn);
    recGear = cfg.strap;
    recN    = recNm ? cfg.rn : '0;
    recM    = recNm ? cfg.rm : '0;
  end

  // active setting, strobe, error flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gearSel  <= '0;
      nVal     <= '0;
      mVal     <= '0;
      nmMode   <= 1'b0;
      loadStb  <= 1'b0;
      ratioErr <= 1'b0;
    end else begin
      loadStb <= wdFire || swApply;
      if (wdFire) begin
        gearSel <= recGear;
        nVal    <= recN;
        mVal    <= recM;
        nmMode  <= recNm;
      end else if (swApply) begin
        gearSel <= swGear;
        nVal    <= swN;
        mVal    <= swM;
        nmMode  <= swNm;
      end
      if (swReject)        ratioErr <= 1'b1;
      else if (stb.errClr) ratioErr <= 1'b0;
    end
  end

  // reset pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseCnt <= '0;
    else if ((wdFire && cfg.rstOnWd) || (swApply && cfg.rstOnChg))
      pulseCnt <= PC_W'(PULSE_CYCLES);
    else if (pulseCnt != '0)
      pulseCnt <= pulseCnt - 1'b1;
  end

  assign rstPulse = (pulseCnt != '0);
endmodule

// File: rtl/fsc_top.sv
module fsc_top
  import fsc_pkg::*;
#(
  parameter int SHORT_TICKS  = 150,
  parameter int LONG_TICKS   = 2500,
  parameter int PULSE_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrLast,
  input  logic [GEAR_W-1:0] strapPins,
  input  logic              porLatch,
  input  logic              msTick,
  input  logic              wdKick,
  output logic [GEAR_W-1:0] gearSel,
  output logic [N_W-1:0]    nVal,
  output logic [M_W-1:0]    mVal,
  output logic              nmMode,
  output logic              loadStb,
  output logic              rstPulse,
  output logic              ratioErr
);
  fscCfg_t cfg;
  fscStb_t stb;

  fsc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrLast(wrLast), .strapPins(strapPins), .porLatch(porLatch),
    .cfg(cfg), .stb(stb)
  );

  fsc_dpath #(
    .SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS), .PULSE_CYCLES(PULSE_CYCLES)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .cfg(cfg), .stb(stb), .msTick(msTick), .wdKick(wdKick),
    .gearSel(gearSel), .nVal(nVal), .mVal(mVal), .nmMode(nmMode),
    .loadStb(loadStb), .rstPulse(rstPulse), .ratioErr(ratioErr)
  );
endmodule

// File: rtl/fsc_chk.sv
module fsc_chk
  import fsc_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [GEAR_W-1:0] gearSel,
  input logic [N_W-1:0]    nVal,
  input logic [M_W-1:0]    mVal,
  input logic              nmMode,
  input logic              loadStb,
  input logic              rstPulse,
  input logic              ratioErr
);
  // R4
  ratio_gt_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmMode |-> (nVal > N_W'(mVal)));

  // R3
  gear_only_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !nmMode |-> (nVal == '0 && mVal == '0));

  // R5
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loadStb |-> $stable({gearSel, nVal, mVal, nmMode}));

  // R9
  pulse_with_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstPulse) |-> loadStb);

  // R6
  reject_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ratioErr) |-> !loadStb);
endmodule

bind fsc_top fsc_chk u_chk (
  .clk(clk), .rstN(rstN), .gearSel(gearSel), .nVal(nVal), .mVal(mVal),
  .nmMode(nmMode), .loadStb(loadStb), .rstPulse(rstPulse), .ratioErr(ratioErr)
);

// File: tb/fsc_top_tb.sv
`timescale 1ns/1ps
module fsc_top_tb;
  logic       clk = 0, rstN = 0;
  logic       wrEn = 0, wrLast = 0, porLatch = 0, msTick = 0, wdKick = 0;
  logic [2:0] wrAddr = 0;
  logic [7:0] wrData = 0;
  logic [4:0] strapPins = 0;
  logic [4:0] gearSel;
  logic [7:0] nVal;
  logic [6:0] mVal;
  logic       nmMode, loadStb, rstPulse, ratioErr;

  int nChk = 0, nBad = 0;
  logic [6:0] mCtrl = 0;
  logic [4:0] mSel = 0, mStrap = 0, eGear = 0;
  logic [7:0] mN = 0, mRn = 0, eN = 0;
  logic [6:0] mM = 0, mRm = 0, eM = 0;
  logic       eNm = 0, eErr = 0, pCfg = 0, pNm = 0;

  always #2.5 clk = ~clk;

  fsc_top u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkOut(input string req);
    check(req, {gearSel, nVal, mVal, nmMode}, {eGear, eN, eM, eNm});
  endtask

  // evaluation model; called right after the triggering edge, checks one cycle later
  task automatic evalModel(input logic nmWr);
    logic [4:0] g; logic [7:0] cn; logic [6:0] cm; logic valid, strobe, pulse;
    g     = mCtrl[1] ? mSel : mStrap;
    valid = !mCtrl[0] || (mN > {1'b0, mM});
    cn    = mCtrl[0] ? mN : 8'h0;
    cm    = mCtrl[0] ? mM : 7'h0;
    strobe = 0;
    if (!valid) eErr = 1;
    else if (nmWr || {g, cn, cm, mCtrl[0]} != {eGear, eN, eM, eNm}) begin
      strobe = 1;
      eGear = g; eN = cn; eM = cm; eNm = mCtrl[0];
    end
    pulse = strobe && mCtrl[5];
    @(negedge clk);
    check("R5 strobe", loadStb, strobe);
    checkOut(mCtrl[0] ? "R4 setting" : "R3 setting");
    check("R6 error flag", ratioErr, eErr);
    check("R9 pulse on change", rstPulse, pulse);
    @(negedge clk);
    check("R5 single strobe", loadStb, 0);
    repeat (17) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic last);
    wrEn = 1; wrAddr = a; wrData = d; wrLast = last;
    @(negedge clk);
    wrEn = 0; wrLast = 0;
    case (a)
      3'd0: begin mCtrl = d[6:0]; if (d[7]) eErr = 0; end
      3'd1: mSel = d[4:0];
      3'd2: mN = d;
      3'd3: mM = d[6:0];
      3'd4: mRn = d;
      3'd5: mRm = d[6:0];
      default: ;
    endcase
    if (a <= 3) pCfg = 1;
    if (a == 2 || a == 3) pNm = 1;
    if (last) begin
      if (pCfg) evalModel(pNm);
      else begin @(negedge clk); check("R5 no eval", loadStb, 0); end
      pCfg = 0; pNm = 0;
    end
  endtask

  task automatic latch(input logic [4:0] v);
    strapPins = v; porLatch = 1;
    @(negedge clk);
    porLatch = 0; mStrap = v;
    evalModel(0);
  endtask

  task automatic kick();
    wdKick = 1; @(negedge clk); wdKick = 0;
  endtask

  initial begin
    #1000000;
    nBad++; nChk++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int hits;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 outputs", {gearSel, nVal, mVal, nmMode, loadStb, rstPulse, ratioErr}, 0);
    rstN = 1;
    @(negedge clk);
    check("R1 after release", {gearSel, loadStb, rstPulse, ratioErr}, 0);

    // R2 strap ignored without latch, captured with it
    strapPins = 5'h1B;
    wr(3'd0, 8'h00, 1);
    check("R2 strap ignored", gearSel, 0);
    latch(5'h13);
    check("R2 strap latched", gearSel, 5'h13);

    // R3 override selects the select field
    wr(3'd1, 8'h07, 1);
    wr(3'd0, 8'h02, 1);
    check("R3 override gear", gearSel, 5'h07);

    // R5 split N/M bytes with idle cycles: one strobe at the end
    wr(3'd2, 8'd120, 0);
    @(negedge clk);
    check("R5 no early load", {loadStb, nVal}, 0);
    wr(3'd3, 8'd40, 0);
    wr(3'd0, 8'h01, 1);
    check("R4 applied N", nVal, 120);

    // R6 equal N and M rejected, then cleared
    wr(3'd2, 8'd40, 0);
    wr(3'd3, 8'd40, 1);
    check("R6 rejected keeps N", nVal, 120);
    check("R6 sticky", ratioErr, 1);
    wr(3'd2, 8'd41, 0);
    wr(3'd0, 8'h81, 1);
    check("R6 cleared", ratioErr, 0);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int nb;
      strapPins = 5'($urandom);
      if (it % 10 == 0) latch(5'($urandom));
      nb = 1 + ($urandom % 3);
      for (int b = 0; b < nb; b++) begin
        logic [2:0] a; logic [7:0] d;
        a = 3'($urandom % 6);
        d = 8'($urandom);
        if (a == 0) d = d & 8'hBF;
        wr(a, d, b == nb - 1);
      end
    end

    // R7 disabled watchdog stays quiet
    wr(3'd2, 8'd100, 0);
    wr(3'd3, 8'd20, 0);
    wr(3'd0, 8'h01, 1);
    msTick = 1;
    hits = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); hits += loadStb; end
    check("R7 disabled", hits, 0);
    msTick = 0;

    // R7 kicks restart the count
    wr(3'd0, 8'h51, 1);
    msTick = 1;
    kick();
    hits = 0;
    for (int k = 0; k < 5; k++) begin
      repeat (100) begin @(negedge clk); hits += loadStb; end
      kick();
    end
    check("R7 kicks hold off", hits, 0);
    // R7 short timeout, R8 strap recovery, R9 pulse on timeout
    repeat (149) @(negedge clk);
    check("R7 one tick early", loadStb, 0);
    @(negedge clk);
    check("R7 short timeout", loadStb, 1);
    eGear = mStrap; eN = 0; eM = 0; eNm = 0;
    checkOut("R8 strap recovery");
    hits = rstPulse;
    for (int i = 0; i < 16; i++) begin @(negedge clk); hits += rstPulse; end
    check("R9 pulse length", hits, 16);
    msTick = 0;

    // R7 long timeout, R8 N/M recovery, R9 no pulse when disabled
    wr(3'd4, 8'd200, 0);
    wr(3'd5, 8'd50, 0);
    wr(3'd0, 8'h4D, 1);
    msTick = 1;
    kick();
    repeat (2499) @(negedge clk);
    check("R7 long early", loadStb, 0);
    @(negedge clk);
    check("R7 long timeout", loadStb, 1);
    eGear = mStrap; eN = 200; eM = 50; eNm = 1;
    checkOut("R8 N/M recovery");
    check("R9 no pulse", rstPulse, 0);
    msTick = 0;
    wr(3'd0, 8'h00, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule